// File: doc/BRIEF.md
# Serial Volume and Tone Command Receiver

This block listens on a three-wire serial control link (serial clock, serial data, enable) as a slave and keeps six audio control codes: master gain, left gain, right gain, treble, bass and the auxiliary-source mix selection. The controller raises enable and clocks in bits most-significant first. When enable drops, the block looks at the frame it has collected. The first two bits received are taken as the device address. The last nine bits are taken as the data word. Any bits between those two fields are ignored.

If the address matches the configured device address, the top three data bits select which code to update. The remaining bits carry the value. Values above the ceiling for their field are clamped to that ceiling. Frames that are too short, carry the wrong address, use an undefined command or select the reserved mix value change nothing. Each frame that is taken produces a one-cycle update strobe. The block outputs raw codes only; converting them to gain is left to the analog path.

The serial inputs are brought into the `clk` domain through a synchroniser chain whose depth is a parameter. The serial clock is then edge-detected in that domain, so it must run well below the system clock.

Top module: `svtone_rx`

## Requirements
- R1: A bit is captured on each rising edge of `ser_clk_i` seen while `ser_en_i` is high, in order of arrival. The frame is evaluated when `ser_en_i` falls. A rising `ser_en_i` starts a new, empty frame.
- R2: A frame changes no output code and gives no strobe if it holds fewer than 11 bits, if its first two bits are not `10`, or if its command field is `110` or `111`.
- R3: The last nine bits of an accepted frame form the data word. Data bits [8:6] are the command, and command `011` loads data bits [5:0] into `master_o`.
- R4: Command `101` loads data bits [4:0] into `left_o`. Command `100` loads data bits [4:0] into `right_o`. Data bit 5 is ignored for both.
- R5: Command `010` loads data bits [3:0] into `treble_o`. Command `001` loads data bits [3:0] into `bass_o`. Data bits [5:4] are ignored for both.
- R6: Command `000` loads data bits [1:0] into `mix_o`, and data bits [5:2] are ignored. The value `11` is reserved: such a frame changes nothing and gives no strobe.
- R7: Values above a ceiling are clamped to it. The ceiling is 40 (`101000`) for master, 20 (`10100`) for left and right, and 12 (`1100`) for treble and bass.
- R8: After reset, master is 40, left and right are 20, treble and bass are 6 (`0110`, flat), mix is `01` and `upd_o` is low.
- R9: `upd_o` is high for exactly one `clk` cycle for each accepted frame. It is high in the first cycle in which the new code appears, and no output code changes in any other cycle.
- R10: In a frame longer than 11 bits, the address is still the first two bits and the data word is still the last nine bits.
- R11: A rising `ser_clk_i` that reaches the synchronised domain in the same cycle as the fall of `ser_en_i` is not captured.
- R12: Rising edges of `ser_clk_i` while `ser_en_i` is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock from the controller |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| ser_en_i | input | 1 | Frame enable, high while a frame is sent |
| master_o | output | 6 | Master gain code |
| left_o | output | 5 | Left channel gain code |
| right_o | output | 5 | Right channel gain code |
| treble_o | output | 4 | Treble code |
| bass_o | output | 4 | Bass code |
| mix_o | output | 2 | Auxiliary mix selection |
| upd_o | output | 1 | One-cycle strobe when a frame is accepted |

## Verification
The last serial clock rise of a frame and the release of enable can reach the synchronised domain in the same cycle. The bench provokes this by switching both inputs at the same instant on the eleventh bit. The frame then has only ten captured bits, so it must leave every code unchanged and give no strobe. The same frame with the clock rise a few cycles before the release must be accepted. Each parameter field is also swept over all of its codes, and the expected clamped value is computed arithmetically.

// File: rtl/svt_pkg.sv
package svt_pkg;
   localparam int ADDR_BITS  = 2;
   localparam int DATA_BITS  = 9;
   localparam int CMD_BITS   = 3;
   localparam int VAL_BITS   = DATA_BITS - CMD_BITS;
   localparam int FRAME_BITS = ADDR_BITS + DATA_BITS;

   localparam int MVOL_W = 6;
   localparam int LR_W   = 5;
   localparam int TONE_W = 4;
   localparam int MIX_W  = 2;

   localparam logic [MVOL_W-1:0] MVOL_MAX = 6'd40;
   localparam logic [LR_W-1:0]   LR_MAX   = 5'd20;
   localparam logic [TONE_W-1:0] TONE_MAX = 4'd12;
   localparam logic [TONE_W-1:0] TONE_FLAT = 4'd6;
   localparam logic [MIX_W-1:0]  MIX_RSV  = 2'b11;
   localparam logic [MIX_W-1:0]  MIX_INIT = 2'b01;

   typedef enum logic [CMD_BITS-1:0] {
      CMD_MIX    = 3'b000,
      CMD_BASS   = 3'b001,
      CMD_TREBLE = 3'b010,
      CMD_MASTER = 3'b011,
      CMD_RIGHT  = 3'b100,
      CMD_LEFT   = 3'b101,
      CMD_UND6   = 3'b110,
      CMD_UND7   = 3'b111
   } svt_cmd_e;
endpackage

// File: rtl/svt_sync_edge.sv
module svt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdat_i,
   input  logic sen_i,
   output logic en_o,
   output logic dat_o,
   output logic clk_rise_o,
   output logic en_rise_o,
   output logic en_fall_o
);
   localparam int W = 3;

   initial assert (STAGES >= 0 && STAGES <= 4)
      else $error("svt_sync_edge: STAGES must lie in 0..4");

   logic [W-1:0] raw;
   logic [W-1:0] s;
   logic [W-1:0] prev;

   assign raw = {sen_i, sclk_i, sdat_i};

   generate
      if (STAGES == 0) begin : g_bypass
         assign s = raw;
      end else begin : g_chain
         logic [W-1:0] q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) q[i] <= '0;
            end else begin
               q[0] <= raw;
               for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
            end
         end
         assign s = q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= s;
   end

   assign en_o       = s[2];
   assign dat_o      = s[0];
   assign clk_rise_o = s[1] & ~prev[1];
   assign en_rise_o  = s[2] & ~prev[2];
   assign en_fall_o  = ~s[2] & prev[2];
endmodule

// File: rtl/svt_shift.sv
module svt_shift
   import svt_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_i,
   input  logic                 dat_i,
   input  logic                 clk_rise_i,
   input  logic                 en_rise_i,
   output logic                 full_o,
   output logic [ADDR_BITS-1:0] addr_o,
   output logic [DATA_BITS-1:0] data_o
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_BITS);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         addr_o <= '0;
         data_o <= '0;
      end else if (en_rise_i) begin
         cnt    <= '0;
         addr_o <= '0;
         data_o <= '0;
      end else if (en_i && clk_rise_i) begin
         data_o <= {data_o[DATA_BITS-2:0], dat_i};
         if (cnt < CNT_ADDR) addr_o <= {addr_o[ADDR_BITS-2:0], dat_i};
         if (cnt < CNT_FULL) cnt <= cnt + 1'b1;
      end
   end

   assign full_o = (cnt == CNT_FULL);

   a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL);

   a_r12_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !en_rise_i) |=> $stable(cnt));
endmodule

// File: rtl/svt_cmd_decode.sv
module svt_cmd_decode
   import svt_pkg::*;
#(
   parameter logic [ADDR_BITS-1:0] DEV_ADDR = 2'b10
) (
   input  logic                 close_i,
   input  logic                 full_i,
   input  logic [ADDR_BITS-1:0] addr_i,
   input  logic [DATA_BITS-1:0] data_i,
   output logic                 accept_o,
   output svt_cmd_e             cmd_o,
   output logic [VAL_BITS-1:0]  val_o
);
   initial assert (VAL_BITS >= MVOL_W)
      else $error("svt_cmd_decode: data word too narrow for master code");

   logic [VAL_BITS-1:0] raw;
   logic                legal;

   assign cmd_o = svt_cmd_e'(data_i[DATA_BITS-1 -: CMD_BITS]);
   assign raw   = data_i[VAL_BITS-1:0];

   always_comb begin
      legal = 1'b1;
      val_o = '0;
      case (cmd_o)
         CMD_MASTER: val_o = VAL_BITS'((raw[MVOL_W-1:0] > MVOL_MAX) ? MVOL_MAX : raw[MVOL_W-1:0]);
         CMD_LEFT, CMD_RIGHT:
            val_o = VAL_BITS'((raw[LR_W-1:0] > LR_MAX) ? LR_MAX : raw[LR_W-1:0]);
         CMD_TREBLE, CMD_BASS:
            val_o = VAL_BITS'((raw[TONE_W-1:0] > TONE_MAX) ? TONE_MAX : raw[TONE_W-1:0]);
         CMD_MIX: begin
            val_o = VAL_BITS'(raw[MIX_W-1:0]);
            legal = (raw[MIX_W-1:0] != MIX_RSV);
         end
         default: legal = 1'b0;
      endcase
   end

   assign accept_o = close_i & full_i & (addr_i == DEV_ADDR) & legal;
endmodule

// File: rtl/svtone_rx.sv
module svtone_rx
   import svt_pkg::*;
#(
   parameter int                   SYNC_STAGES = 2,
   parameter logic [ADDR_BITS-1:0] DEV_ADDR    = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              ser_en_i,
   output logic [MVOL_W-1:0] master_o,
   output logic [LR_W-1:0]   left_o,
   output logic [LR_W-1:0]   right_o,
   output logic [TONE_W-1:0] treble_o,
   output logic [TONE_W-1:0] bass_o,
   output logic [MIX_W-1:0]  mix_o,
   output logic              upd_o
);
   logic                 en_s, dat_s, clk_rise, en_rise, en_fall;
   logic                 full;
   logic [ADDR_BITS-1:0] addr;
   logic [DATA_BITS-1:0] data;
   logic                 accept;
   svt_cmd_e             cmd;
   logic [VAL_BITS-1:0]  val;

   svt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .sclk_i(ser_clk_i), .sdat_i(ser_dat_i), .sen_i(ser_en_i),
      .en_o(en_s), .dat_o(dat_s),
      .clk_rise_o(clk_rise), .en_rise_o(en_rise), .en_fall_o(en_fall)
   );

   svt_shift u_shift (
      .clk(clk), .rst_n(rst_n),
      .en_i(en_s), .dat_i(dat_s),
      .clk_rise_i(clk_rise), .en_rise_i(en_rise),
      .full_o(full), .addr_o(addr), .data_o(data)
   );

   svt_cmd_decode #(.DEV_ADDR(DEV_ADDR)) u_dec (
      .close_i(en_fall), .full_i(full), .addr_i(addr), .data_i(data),
      .accept_o(accept), .cmd_o(cmd), .val_o(val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_o <= MVOL_MAX;
         left_o   <= LR_MAX;
         right_o  <= LR_MAX;
         treble_o <= TONE_FLAT;
         bass_o   <= TONE_FLAT;
         mix_o    <= MIX_INIT;
         upd_o    <= 1'b0;
      end else begin
         upd_o <= accept;
         if (accept) begin
            case (cmd)
               CMD_MASTER: master_o <= val[MVOL_W-1:0];
               CMD_LEFT:   left_o   <= val[LR_W-1:0];
               CMD_RIGHT:  right_o  <= val[LR_W-1:0];
               CMD_TREBLE: treble_o <= val[TONE_W-1:0];
               CMD_BASS:   bass_o   <= val[TONE_W-1:0];
               CMD_MIX:    mix_o    <= val[MIX_W-1:0];
               default: ;
            endcase
         end
      end
   end

   logic [MVOL_W+2*LR_W+2*TONE_W+MIX_W-1:0] codes;
   assign codes = {master_o, left_o, right_o, treble_o, bass_o, mix_o};

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);
   a_r9_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |-> $stable(codes));
   a_r7_master_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      master_o <= MVOL_MAX);
   a_r7_lr_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (left_o <= LR_MAX) && (right_o <= LR_MAX));
   a_r7_tone_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (treble_o <= TONE_MAX) && (bass_o <= TONE_MAX));
   a_r6_no_reserved_mix: assert property (@(posedge clk) disable iff (!rst_n)
      mix_o != MIX_RSV);
endmodule

// File: tb/svtone_rx_test.sv
module svtone_rx_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
   logic [5:0] master;
   logic [4:0] left, right;
   logic [3:0] treble, bass;
   logic [1:0] mix;
   logic       upd;

   int checks = 0, errors = 0, strobes = 0;
   bit done = 1'b0;
   int e_m = 40, e_l = 20, e_r = 20, e_t = 6, e_b = 6, e_x = 1;

   always #2 clk = ~clk;

   svtone_rx uut (
      .clk(clk), .rst_n(rst_n),
      .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_en_i(ser_en),
      .master_o(master), .left_o(left), .right_o(right),
      .treble_o(treble), .bass_o(bass), .mix_o(mix), .upd_o(upd)
   );

   always @(posedge clk) if (rst_n && upd) strobes++;

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic chk_all(input string tag, input int s0, input int exp_str);
      chk({tag, " master"}, master, e_m);
      chk({tag, " left"}, left, e_l);
      chk({tag, " right"}, right, e_r);
      chk({tag, " treble"}, treble, e_t);
      chk({tag, " bass"}, bass, e_b);
      chk({tag, " mix"}, mix, e_x);
      chk({tag, " strobes"}, strobes - s0, exp_str);
   endtask

   task automatic send(input logic [31:0] pat, input int n, input bit clash);
      ser_en = 1'b1;
      wclk(4);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = pat[i];
         wclk(4);
         ser_clk = 1'b1;
         if (clash && i == 0) ser_en = 1'b0;
         wclk(4);
         ser_clk = 1'b0;
      end
      wclk(2);
      ser_en = 1'b0;
      wclk(10);
   endtask

   function automatic logic [31:0] frm(input logic [2:0] cmd, input logic [5:0] v);
      return {21'd0, 2'b10, cmd, v};
   endfunction

   function automatic int clampi(input int v, input int lim);
      return (v > lim) ? lim : v;
   endfunction

   initial begin
      int s0;
      wclk(3);
      chk_all("R8 reset", 0, 0);
      chk("R8 upd low", upd, 0);
      rst_n = 1'b1;
      wclk(3);

      for (int v = 0; v < 64; v++) begin
         s0 = strobes;
         send(frm(3'b011, 6'(v)), 11, 1'b0);
         e_m = clampi(v, 40);
         chk_all("R3 R7 master sweep", s0, 1);
      end
      for (int v = 0; v < 32; v++) begin
         s0 = strobes;
         send(frm(3'b101, {v[0], 5'(v)}), 11, 1'b0);
         e_l = clampi(v, 20);
         chk_all("R4 R7 left sweep", s0, 1);
         s0 = strobes;
         send(frm(3'b100, {~v[0], 5'(v)}), 11, 1'b0);
         e_r = clampi(v, 20);
         chk_all("R4 R7 right sweep", s0, 1);
      end
      for (int v = 0; v < 16; v++) begin
         s0 = strobes;
         send(frm(3'b010, {v[1:0], 4'(v)}), 11, 1'b0);
         e_t = clampi(v, 12);
         chk_all("R5 R7 treble sweep", s0, 1);
         s0 = strobes;
         send(frm(3'b001, {~v[1:0], 4'(v)}), 11, 1'b0);
         e_b = clampi(v, 12);
         chk_all("R5 R7 bass sweep", s0, 1);
      end
      for (int v = 0; v < 4; v++) begin
         s0 = strobes;
         send(frm(3'b000, {4'b1010, 2'(v)}), 11, 1'b0);
         if (v != 3) e_x = v;
         chk_all("R6 mix sweep", s0, (v != 3) ? 1 : 0);
      end

      // R2: wrong device addresses
      for (int a = 0; a < 4; a++) begin
         if (a == 2) continue;
         s0 = strobes;
         send({21'd0, 2'(a), 3'b011, 6'd5}, 11, 1'b0);
         chk_all("R2 wrong address", s0, 0);
      end
      // R2: short frame, undefined commands
      s0 = strobes;
      send({22'd0, 2'b10, 3'b011, 5'd3}, 10, 1'b0);
      chk_all("R2 short frame", s0, 0);
      s0 = strobes;
      send(frm(3'b110, 6'd1), 11, 1'b0);
      chk_all("R2 command 110", s0, 0);
      s0 = strobes;
      send(frm(3'b111, 6'd1), 11, 1'b0);
      chk_all("R2 command 111", s0, 0);

      // R10: long frames
      s0 = strobes;
      send({18'd0, 2'b10, 3'b111, 3'b011, 6'd17}, 14, 1'b0);
      e_m = 17;
      chk_all("R10 long frame accepted", s0, 1);
      s0 = strobes;
      send({18'd0, 2'b01, 3'b010, 3'b011, 6'd9}, 14, 1'b0);
      chk_all("R10 long frame bad leading address", s0, 0);

      // R11: last clock rise coincides with enable release
      s0 = strobes;
      send(frm(3'b011, 6'd25), 11, 1'b1);
      chk_all("R11 coincident edge dropped", s0, 0);
      s0 = strobes;
      send(frm(3'b011, 6'd25), 11, 1'b0);
      e_m = 25;
      chk_all("R11 R1 control frame", s0, 1);

      // R12: clock activity while enable is low
      s0 = strobes;
      for (int i = 0; i < 12; i++) begin
         ser_dat = i[0];
         wclk(4);
         ser_clk = 1'b1;
         wclk(4);
         ser_clk = 0;
      end
      wclk(10);
      chk_all("R12 idle clocks", s0, 0);
      s0 = strobes;
      send(frm(3'b000, 6'd2), 11, 1'b0);
      e_x = 2;
      chk_all("R12 R1 frame after idle clocks", s0, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule